// File: doc/BRIEF.md
# I2C Slave Receiver with Per-Byte Clock Stretching

This block is a bus-side I2C target that only receives. It samples SCL and SDA with the system clock and finds START and STOP conditions from the sampled levels. It compares the first frame after a START with a 7-bit own address and acknowledges matching frames. It then shifts in data bytes and places each complete byte in a holding register for a local host. After the ninth clock of every data byte it pulls SCL low. SCL stays low until the host has taken the byte. The bus controller therefore cannot run ahead of a slow host.

The host works through a small register port: a data register, a control register and a status register. The control register sets the acknowledge value, the interrupt enable and a mask for STOP interrupts. The status register reports the interrupt flag, buffer-full, bus-busy, STOP-seen and read-request. A read request from the controller is only flagged. The block never sends data, so after acknowledging such an address it ignores the bus until the next START. Both bus lines are open-drain: an output enable of 1 pulls the line low.

Top module: `i2c_stretch_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) sets busy (status bit 2). A STOP (SDA rises while SCL is high) clears busy and sets the STOP flag (status bit 3). All status and control bits are 0 after reset.
- R2: The first frame after a START carries the address in its upper 7 bits, MSB first, and the direction in bit 0. For direction 0 the following frames are received as data. For direction 1 the block sets the read-request flag (status bit 4) and the interrupt flag, serves no data, and ignores the bus until the next START. The read-request flag is cleared by the next START.
- R3: When the address does not match, the block neither acknowledges nor stores nor stretches, and it drives neither line until the next START.
- R4: On the ninth clock of an addressed frame, SDA is pulled low when control bit 0 is 0 (ACK) and left released when it is 1 (NACK). At all other times SDA is released.
- R5: The rising edge of the ninth SCL pulse of a data byte sets the interrupt flag (status bit 0). irq_o is high when both the flag and the enable (control bit 1) are 1.
- R6: On the rising edge of the ninth SCL pulse of a data byte, the byte, shifted in MSB first, moves into the data register (address 0) and buffer-full (status bit 1) is set.
- R7: From the falling edge of the ninth SCL pulse of a data byte, SCL is held low until the host reads address 0. That read clears buffer-full and releases SCL. Address frames are not stretched.
- R8: A STOP sets the interrupt flag only when the STOP mask (control bit 2) is 0.
- R9: Writing status (address 2) with bit 0 at 0 clears the interrupt flag, and with bit 3 at 0 clears the STOP flag. Writing 1 to either bit leaves it as it is.
- R10: A START in the middle of a frame restarts the bit count and address matching, and busy stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (stretch) |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| own_addr_i | input | ADDR_W | Own 7-bit address |
| reg_addr_i | input | 2 | Host register select: 0 data, 1 control, 2 status |
| reg_wr_i | input | 1 | Host write strobe |
| reg_rd_i | input | 1 | Host read strobe |
| reg_wdata_i | input | DATA_W | Host write data |
| reg_rdata_o | output | DATA_W | Host read data, combinational on reg_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sends random data bytes through a bus controller model that honours stretching. After each byte it checks that SCL stays low for many cycles and is released only after the data read. A design that released SCL early would lose bytes, and one that never released would hang the watchdog. It sends random non-matching addresses and checks that nothing is acknowledged or stored, and it checks that a read request is flagged without any stretch. It checks the NACK on the last byte and the STOP-interrupt masking. It checks that writing 1 to a flag bit leaves that flag set. It checks a START cut into the middle of a frame, which a design that kept its bit count would misframe.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  typedef enum logic [1:0] {FR_IDLE, FR_ADDR, FR_DATA} frame_st_e;

  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  localparam int C_NACK  = 0;
  localparam int C_IRQEN = 1;
  localparam int C_SMASK = 2;

  localparam int S_IRQ  = 0;
  localparam int S_FULL = 1;
  localparam int S_BUSY = 2;
  localparam int S_STOP = 3;
  localparam int S_RDRQ = 4;
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_ff[g] <= 1'b1;
        sda_ff[g] <= 1'b1;
      end else if (g == 0) begin
        scl_ff[g] <= scl_i;
        sda_ff[g] <= sda_i;
      end else begin
        scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
        sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_srx_frame.sv
module i2c_srx_frame
  import i2c_srx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              nack_i,
  input  logic              full_i,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  output logic              byte_ev_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              rdreq_ev_o
);
  localparam int CW      = $clog2(DATA_W + 2);
  localparam int ACK_CNT = DATA_W;
  localparam int END_CNT = DATA_W + 1;

  frame_st_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              ack_q, hold_q, ninth;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= FR_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      ack_q <= 1'b0;
    end else if (start_i) begin
      st_q  <= FR_ADDR;
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else if (stop_i) begin
      st_q  <= FR_IDLE;
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else if (st_q != FR_IDLE) begin
      if (scl_rise_i) begin
        if (cnt_q < CW'(ACK_CNT)) begin
          sh_q  <= {sh_q[DATA_W-2:0], sda_i};
          cnt_q <= cnt_q + 1'b1;
          // address decided after the last address/dir bit
          if (st_q == FR_ADDR && cnt_q == CW'(ACK_CNT - 1) &&
              sh_q[ADDR_W-1:0] != own_addr_i) begin
            st_q  <= FR_IDLE;
            cnt_q <= '0;
          end
        end else if (cnt_q == CW'(ACK_CNT)) begin
          cnt_q <= CW'(END_CNT);
        end
      end else if (scl_fall_i) begin
        if (cnt_q == CW'(ACK_CNT)) begin
          ack_q <= ~nack_i;
        end else if (cnt_q == CW'(END_CNT)) begin
          ack_q <= 1'b0;
          cnt_q <= '0;
          if (st_q == FR_ADDR) st_q <= sh_q[0] ? FR_IDLE : FR_DATA;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else if (!full_i) hold_q <= 1'b0;
    else if (st_q == FR_DATA && scl_fall_i && !start_i && !stop_i &&
             cnt_q == CW'(END_CNT)) hold_q <= 1'b1;
  end

  assign ninth      = scl_rise_i && !start_i && !stop_i && cnt_q == CW'(ACK_CNT);
  assign byte_ev_o  = ninth && st_q == FR_DATA;
  assign rdreq_ev_o = ninth && st_q == FR_ADDR && sh_q[0];
  assign byte_o     = sh_q;
  assign sda_oe_o   = ack_q;
  assign scl_oe_o   = hold_q;

  p_release_on_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_i) |=> !scl_oe_o);
  p_sda_quiet_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FR_IDLE) |-> !sda_oe_o);
  p_ack_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (cnt_q == CW'(ACK_CNT) || cnt_q == CW'(END_CNT)));
endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs
  import i2c_srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_ev_i,
  input  logic              stop_ev_i,
  input  logic              byte_ev_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              rdreq_ev_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              full_o,
  output logic              nack_o
);
  logic [DATA_W-1:0] rxbuf_q;
  logic irq_q, full_q, busy_q, stop_q, rdrq_q;
  logic nack_q, irqen_q, smask_q;
  logic wr_stat, wr_ctrl, rd_data;
  logic unused_wbits;

  assign wr_stat = reg_wr_i && reg_addr_i == RA_STAT;
  assign wr_ctrl = reg_wr_i && reg_addr_i == RA_CTRL;
  assign rd_data = reg_rd_i && reg_addr_i == RA_DATA;
  assign unused_wbits = ^reg_wdata_i[DATA_W-1:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxbuf_q <= '0;
      irq_q   <= 1'b0;
      full_q  <= 1'b0;
      busy_q  <= 1'b0;
      stop_q  <= 1'b0;
      rdrq_q  <= 1'b0;
      nack_q  <= 1'b0;
      irqen_q <= 1'b0;
      smask_q <= 1'b0;
    end else begin
      if (byte_ev_i) rxbuf_q <= byte_i;

      if (byte_ev_i || rdreq_ev_i || (stop_ev_i && !smask_q)) irq_q <= 1'b1;
      else if (wr_stat && !reg_wdata_i[S_IRQ]) irq_q <= 1'b0;

      if (byte_ev_i) full_q <= 1'b1;
      else if (rd_data) full_q <= 1'b0;

      if (start_ev_i) busy_q <= 1'b1;
      else if (stop_ev_i) busy_q <= 1'b0;

      if (stop_ev_i) stop_q <= 1'b1;
      else if (wr_stat && !reg_wdata_i[S_STOP]) stop_q <= 1'b0;

      if (rdreq_ev_i) rdrq_q <= 1'b1;
      else if (start_ev_i) rdrq_q <= 1'b0;

      if (wr_ctrl) begin
        nack_q  <= reg_wdata_i[C_NACK];
        irqen_q <= reg_wdata_i[C_IRQEN];
        smask_q <= reg_wdata_i[C_SMASK];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_DATA: reg_rdata_o = rxbuf_q;
      RA_CTRL: begin
        reg_rdata_o[C_NACK]  = nack_q;
        reg_rdata_o[C_IRQEN] = irqen_q;
        reg_rdata_o[C_SMASK] = smask_q;
      end
      RA_STAT: begin
        reg_rdata_o[S_IRQ]  = irq_q;
        reg_rdata_o[S_FULL] = full_q;
        reg_rdata_o[S_BUSY] = busy_q;
        reg_rdata_o[S_STOP] = stop_q;
        reg_rdata_o[S_RDRQ] = rdrq_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o  = irq_q & irqen_q;
  assign full_o = full_q;
  assign nack_o = nack_q;

  p_full_on_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ev_i |=> (full_q && rxbuf_q == $past(byte_i)));
  p_irq_on_byte_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_ev_i || rdreq_ev_i) |=> irq_q);
  p_busy_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ev_i |=> busy_q);
  p_busy_clr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_ev_i && !start_ev_i) |=> (!busy_q && stop_q));
  p_stop_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_ev_i && smask_q && !irq_q && !byte_ev_i && !rdreq_ev_i) |=> !irq_q);
endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = ADDR_W + 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic byte_ev, rdreq_ev, full, nack;
  logic [DATA_W-1:0] byte_val;

  i2c_srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  i2c_srx_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .sda_i      (sda_s),
    .own_addr_i (own_addr_i),
    .nack_i     (nack),
    .full_i     (full),
    .sda_oe_o   (sda_oe_o),
    .scl_oe_o   (scl_oe_o),
    .byte_ev_o  (byte_ev),
    .byte_o     (byte_val),
    .rdreq_ev_o (rdreq_ev)
  );

  i2c_srx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_ev_i  (start_ev),
    .stop_ev_i   (stop_ev),
    .byte_ev_i   (byte_ev),
    .byte_i      (byte_val),
    .rdreq_ev_i  (rdreq_ev),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .full_o      (full),
    .nack_o      (nack)
  );
endmodule

// File: tb/i2c_stretch_slave_test.sv
module i2c_stretch_slave_test;
  localparam logic [6:0] OWN = 7'h2A;
  localparam int T = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic [1:0] raddr = '0;
  logic rwr = 1'b0, rrd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic scl_bus, sda_bus;
  int checks = 0, errors = 0;

  always #4ns clk = ~clk;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_stretch_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(OWN),
    .reg_addr_i(raddr), .reg_wr_i(rwr), .reg_rd_i(rrd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] stat(input bit i, f, b, s, r);
    return {3'b000, r, s, b, f, i};
  endfunction

  function automatic bit exp_ack(input logic [7:0] a);
    return a[7:1] == OWN;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    int w = 0;
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_bus && w < 20000) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    raddr = a; wdata = d; rwr = 1'b1;
    @(negedge clk);
    rwr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    raddr = a; rrd = 1'b1;
    #1ns d = rdata;
    @(negedge clk);
    rrd = 1'b0;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; cyc(T);
    scl_up(); cyc(T);
    m_sda = 1'b0; cyc(T);
    m_scl = 1'b0; cyc(T);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; cyc(T);
    scl_up(); cyc(T);
    m_sda = 1'b1; cyc(T);
  endtask

  task automatic bus_bit(input bit b);
    m_sda = b; cyc(T);
    scl_up(); cyc(T);
    m_scl = 1'b0; cyc(T);
  endtask

  task automatic bus_byte(input logic [7:0] b, output bit ack);
    for (int k = 7; k >= 0; k--) bus_bit(b[k]);
    m_sda = 1'b1; cyc(T);
    scl_up(); cyc(T / 2);
    ack = !sda_bus;
    cyc(T / 2);
    m_scl = 1'b0; cyc(T);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, b;
    bit ack;
    void'($urandom(32'h51A7));
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    // reset state
    host_rd(2'd2, d); chk("R1 reset status", d, 8'h00);
    host_rd(2'd1, d); chk("R1 reset control", d, 8'h00);
    chk("R7 reset scl", scl_oe, 0);
    chk("R4 reset sda", sda_oe, 0);
    chk("R5 reset irq", irq, 0);

    // write transfer with random bytes
    host_wr(2'd1, 8'h02);
    bus_start();
    host_rd(2'd2, d); chk("R1 busy after start", d, stat(0, 0, 1, 0, 0));
    bus_byte({OWN, 1'b0}, ack);
    chk("R2 address ack", ack, 1);
    chk("R7 no stretch on address", scl_oe, 0);
    host_rd(2'd2, d); chk("R2 no irq for write address", d, stat(0, 0, 1, 0, 0));
    for (int i = 0; i < 6; i++) begin
      b = 8'($urandom);
      if (i == 5) host_wr(2'd1, 8'h03);
      bus_byte(b, ack);
      chk("R4 ack value", ack, (i < 5) ? 1 : 0);
      chk("R7 stretch begins", scl_oe, 1);
      host_rd(2'd2, d); chk("R5 R6 byte flags", d, stat(1, 1, 1, 0, 0));
      chk("R5 irq output", irq, 1);
      cyc(40);
      chk("R7 stretch holds", scl_oe, 1);
      chk("R7 bus clock low", scl_bus, 0);
      if (i == 0) begin
        host_wr(2'd2, 8'h09);
        host_rd(2'd2, d); chk("R9 write one keeps irq", d, stat(1, 1, 1, 0, 0));
      end
      host_rd(2'd0, d); chk("R6 received byte", d, b);
      cyc(3);
      chk("R7 released after read", scl_oe, 0);
      host_rd(2'd2, d); chk("R6 full cleared by read", d, stat(1, 0, 1, 0, 0));
      host_wr(2'd2, 8'h08);
      host_rd(2'd2, d); chk("R9 irq cleared", d, stat(0, 0, 1, 0, 0));
      chk("R5 irq output low", irq, 0);
    end
    bus_stop();
    host_rd(2'd2, d); chk("R1 R8 stop flags", d, stat(1, 0, 0, 1, 0));
    chk("R8 irq output on stop", irq, 1);
    host_wr(2'd2, 8'h01);
    host_rd(2'd2, d); chk("R9 stop cleared irq kept", d, stat(1, 0, 0, 0, 0));
    host_wr(2'd2, 8'h00);

    // stop interrupt masked
    host_wr(2'd1, 8'h06);
    bus_start();
    bus_byte({OWN, 1'b0}, ack);
    chk("R2 address ack again", ack, 1);
    b = 8'($urandom);
    bus_byte(b, ack);
    host_rd(2'd0, d); chk("R6 byte under mask", d, b);
    host_wr(2'd2, 8'h00);
    bus_stop();
    host_rd(2'd2, d); chk("R8 masked stop", d, stat(0, 0, 0, 1, 0));
    chk("R8 irq output masked", irq, 0);
    host_wr(2'd2, 8'h00);

    // non-matching addresses
    host_wr(2'd1, 8'h02);
    for (int i = 0; i < 3; i++) begin
      b = 8'($urandom);
      if (exp_ack(b)) b[7] = ~b[7];
      bus_start();
      bus_byte(b, ack);
      chk("R3 no ack on mismatch", ack, exp_ack(b));
      bus_byte(8'($urandom), ack);
      chk("R3 data ignored ack", ack, 0);
      chk("R3 no stretch", scl_oe, 0);
      host_rd(2'd2, d); chk("R3 nothing stored", d, stat(0, 0, 1, 0, 0));
      bus_stop();
      host_wr(2'd2, 8'h00);
    end

    // read request
    bus_start();
    bus_byte({OWN, 1'b1}, ack);
    chk("R2 read address ack", ack, 1);
    chk("R2 no stretch on read", scl_oe, 0);
    host_rd(2'd2, d); chk("R2 read request flag", d, stat(1, 0, 1, 0, 1));
    bus_byte(8'h00, ack);
    chk("R2 ignored after read request", ack, 0);
    chk("R2 no stretch after read", scl_oe, 0);
    bus_stop();
    host_rd(2'd2, d); chk("R2 flags after stop", d, stat(1, 0, 0, 1, 1));
    host_wr(2'd2, 8'h00);

    // repeated start mid frame
    bus_start();
    host_rd(2'd2, d); chk("R2 read request cleared by start", d, stat(0, 0, 1, 0, 0));
    for (int k = 0; k < 4; k++) bus_bit(1'($urandom));
    bus_start();
    host_rd(2'd2, d); chk("R10 busy held", d, stat(0, 0, 1, 0, 0));
    bus_byte({OWN, 1'b0}, ack);
    chk("R10 address after restart", ack, 1);
    b = 8'($urandom);
    bus_byte(b, ack);
    chk("R10 data ack", ack, 1);
    chk("R10 stretch", scl_oe, 1);
    host_rd(2'd0, d); chk("R10 byte after restart", d, b);
    host_wr(2'd2, 8'h00);
    bus_stop();
    cyc(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule